// File: doc/BRIEF.md
# Store Lane Formatter

This block prepares the write side of a 64-bit memory port for a register store. It takes a 64-bit source value, an access size of one, two, four or eight bytes, a byte-reverse request and the three low address bits. From these it produces the lane-aligned write data and a per-lane byte-enable mask. A store writes only the low-order part of the register that matches its size. In the normal mode the most significant stored byte goes to the lowest address. In the reversed mode the least significant byte goes to the lowest address.

Lane k of the port holds the byte at address offset k from the aligned 8-byte base, so lane 0 is the lowest address. Stored data begins at the lane named by the address bits. An access that would run past lane 7 cannot be done in one beat, so it is reported and writes nothing. A reversed one-byte store is not a legal request and is reported the same way. Results leave a register stage one cycle after a valid input.

Top module: `store_lane_formatter`

## Requirements
- R1: While reset is asserted, `out_vld_o`, `misalign_o`, `wdata_o` and `byte_en_o` are all zero.
- R2: `out_vld_o` is high exactly in the cycle after a cycle in which `in_vld_i` was high.
- R3: For an accepted access that is not flagged, `byte_en_o` has N contiguous bits set starting at bit `addr_lo_i`. Bit k enables lane k. The size code gives N: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8.
- R4: In normal mode (`reverse_i`=0), the byte at offset `addr_lo_i`+i receives register byte N-1-i, where register byte 0 is `src_i[7:0]`. A one-byte store therefore writes `src_i[7:0]`.
- R5: In reversed mode (`reverse_i`=1), the byte at offset `addr_lo_i`+i receives register byte i, so the least significant byte lands at the lowest address.
- R6: An 8-byte store at offset 0 enables all eight lanes and carries the whole register.
- R7: When `addr_lo_i` + N exceeds 8, `misalign_o` is raised and both `byte_en_o` and `wdata_o` are zero.
- R8: A reversed one-byte request (size code 0 with `reverse_i`=1) raises `misalign_o` and clears `byte_en_o` and `wdata_o`.
- R9: Lane k occupies `wdata_o[63-8k -: 8]`. Every lane whose enable is clear carries zero.
- R10: Register bytes above the access size never appear in `wdata_o`.
- R11: In a cycle where `in_vld_i` is low, `wdata_o`, `byte_en_o` and `misalign_o` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld_i | input | 1 | Store request present |
| src_i | input | 64 | Source register value |
| size_i | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| reverse_i | input | 1 | Byte-reversed store request |
| addr_lo_i | input | 3 | Low three effective-address bits |
| out_vld_o | output | 1 | Formatted result present |
| wdata_o | output | 64 | Lane-aligned write data |
| byte_en_o | output | 8 | Per-lane write enable, bit k for lane k |
| misalign_o | output | 1 | Request crosses the port or is illegal |

## Verification
The assertions assume that every input holds a known value at each clock edge, including `in_vld_i`, which stays low while reset is asserted and during the two synchronizer cycles after it. The byte-count and hold properties compare the outputs with inputs sampled one edge earlier. For that reason the bench changes inputs only on falling edges and keeps `in_vld_i` low until the internal reset has been released. The stimulus sweeps every size code, both modes and every address offset with two source patterns whose upper bytes are non-zero. It then ends with idle cycles that change the data inputs without a valid request.

// File: rtl/stfmt_pkg.sv
package stfmt_pkg;

  localparam int BYTE_W = 8;

  // Access size code: number of bytes is 1 << code
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } st_size_e;

endpackage

// File: rtl/stfmt_byte_order.sv
// Picks the low-order bytes of the register that the access size covers and
// lists them in ascending address order (element 0 goes to the lowest address).
module stfmt_byte_order
  import stfmt_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFFW = $clog2(LANES),
  localparam int SZW  = $clog2(OFFW + 1)
) (
  input  logic [LANES-1:0][BYTE_W-1:0] src_i,
  input  logic [SZW-1:0]               size_i,
  input  logic                         rev_i,
  output logic [LANES-1:0][BYTE_W-1:0] seq_o
);

  logic [OFFW:0] nbytes;

  always_comb begin
    nbytes = (OFFW+1)'(1) << size_i;
  end

  always_comb begin
    logic [OFFW:0] pos;
    logic [OFFW:0] mirror;
    for (int i = 0; i < LANES; i++) begin
      pos    = (OFFW+1)'(i);
      mirror = nbytes - (OFFW+1)'(1) - pos;
      if (pos < nbytes) begin
        if (rev_i) seq_o[i] = src_i[pos[OFFW-1:0]];
        else       seq_o[i] = src_i[mirror[OFFW-1:0]];
      end else begin
        seq_o[i] = '0;
      end
    end
  end

endmodule

// File: rtl/stfmt_lane_steer.sv
// Moves the address-ordered bytes to the port lanes starting at the offset.
module stfmt_lane_steer
  import stfmt_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFFW = $clog2(LANES),
  localparam int SZW  = $clog2(OFFW + 1)
) (
  input  logic [LANES-1:0][BYTE_W-1:0] seq_i,
  input  logic [OFFW-1:0]              off_i,
  input  logic [SZW-1:0]               size_i,
  output logic [LANES-1:0][BYTE_W-1:0] lane_o,
  output logic [LANES-1:0]             hit_o
);

  logic [OFFW:0] nbytes;
  logic [OFFW:0] off_ext;

  always_comb begin
    nbytes  = (OFFW+1)'(1) << size_i;
    off_ext = {1'b0, off_i};
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFFW:0] LANE_IDX = (OFFW+1)'(k);
    logic [OFFW:0] rel;
    always_comb begin
      rel       = LANE_IDX - off_ext;
      hit_o[k]  = (off_ext <= LANE_IDX) && (rel < nbytes);
      lane_o[k] = hit_o[k] ? seq_i[rel[OFFW-1:0]] : '0;
    end
  end

endmodule

// File: rtl/stfmt_fault_check.sv
// Flags a request that runs past the last lane or is a reversed single byte.
module stfmt_fault_check
  import stfmt_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFFW = $clog2(LANES),
  localparam int SZW  = $clog2(OFFW + 1)
) (
  input  logic [OFFW-1:0] off_i,
  input  logic [SZW-1:0]  size_i,
  input  logic            rev_i,
  output logic            fault_o
);

  logic [OFFW+1:0] end_pos;
  logic            crosses;
  logic            bad_rev;

  always_comb begin
    end_pos = (OFFW+2)'(off_i) + ((OFFW+2)'(1) << size_i);
    crosses = end_pos > (OFFW+2)'(LANES);
    bad_rev = rev_i && (st_size_e'(size_i) == SZ_BYTE);
    fault_o = crosses || bad_rev;
  end

endmodule

// File: rtl/store_lane_formatter.sv
module store_lane_formatter
  import stfmt_pkg::*;
#(
  parameter int LANES = 8,
  localparam int OFFW = $clog2(LANES),
  localparam int SZW  = $clog2(OFFW + 1),
  localparam int DW   = LANES * BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld_i,
  input  logic [DW-1:0]   src_i,
  input  logic [SZW-1:0]  size_i,
  input  logic            reverse_i,
  input  logic [OFFW-1:0] addr_lo_i,
  output logic            out_vld_o,
  output logic [DW-1:0]   wdata_o,
  output logic [LANES-1:0] byte_en_o,
  output logic            misalign_o
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_core_n = rst_sync_q[1];

  // Datapath
  logic [LANES-1:0][BYTE_W-1:0] src_b;
  logic [LANES-1:0][BYTE_W-1:0] seq_b;
  logic [LANES-1:0][BYTE_W-1:0] lane_b;
  logic [LANES-1:0]             hit;
  logic                         fault;

  assign src_b = src_i;

  stfmt_byte_order #(.LANES(LANES)) u_order (
    .src_i  (src_b),
    .size_i (size_i),
    .rev_i  (reverse_i),
    .seq_o  (seq_b)
  );

  stfmt_lane_steer #(.LANES(LANES)) u_steer (
    .seq_i  (seq_b),
    .off_i  (addr_lo_i),
    .size_i (size_i),
    .lane_o (lane_b),
    .hit_o  (hit)
  );

  stfmt_fault_check #(.LANES(LANES)) u_fault (
    .off_i   (addr_lo_i),
    .size_i  (size_i),
    .rev_i   (reverse_i),
    .fault_o (fault)
  );

  // Next-state: lane k sits at the most significant end for k = 0
  logic [DW-1:0]    wdata_d;
  logic [LANES-1:0] be_d;
  logic             mis_d;

  for (genvar k = 0; k < LANES; k++) begin : g_pack
    assign wdata_d[DW-1-BYTE_W*k -: BYTE_W] = fault ? '0 : lane_b[k];
  end

  always_comb begin
    be_d  = fault ? '0 : hit;
    mis_d = fault;
  end

  // Registers
  logic            vld_q;
  logic [DW-1:0]   wdata_q;
  logic [LANES-1:0] be_q;
  logic            mis_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) vld_q <= 1'b0;
    else             vld_q <= in_vld_i;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wdata_q <= '0;
      be_q    <= '0;
      mis_q   <= 1'b0;
    end else if (in_vld_i) begin
      wdata_q <= wdata_d;
      be_q    <= be_d;
      mis_q   <= mis_d;
    end
  end

  assign out_vld_o  = vld_q;
  assign wdata_o    = wdata_q;
  assign byte_en_o  = be_q;
  assign misalign_o = mis_q;

  // Assertions
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_vld_i |=> out_vld_o);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_vld_i |=> !out_vld_o);

  a_r3_enable_count: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_vld_o && !misalign_o) |->
      ($countones(byte_en_o) == (32'd1 << $past(size_i))));

  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    misalign_o |-> (byte_en_o == '0 && wdata_o == '0));

  a_r8_reverse_byte: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_vld_i && reverse_i && size_i == '0) |=> misalign_o);

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_vld_i |=> ($stable(wdata_o) && $stable(byte_en_o) && $stable(misalign_o)));

endmodule

// File: tb/store_lane_formatter_bench.sv
`timescale 1ns/1ps
module store_lane_formatter_bench;

  logic        clk;
  logic        rst_n;
  logic        in_vld_i;
  logic [63:0] src_i;
  logic [1:0]  size_i;
  logic        reverse_i;
  logic [2:0]  addr_lo_i;
  logic        out_vld_o;
  logic [63:0] wdata_o;
  logic [7:0]  byte_en_o;
  logic        misalign_o;

  int n_chk;
  int n_fail;

  store_lane_formatter u_store_lane_formatter (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld_i   (in_vld_i),
    .src_i      (src_i),
    .size_i     (size_i),
    .reverse_i  (reverse_i),
    .addr_lo_i  (addr_lo_i),
    .out_vld_o  (out_vld_o),
    .wdata_o    (wdata_o),
    .byte_en_o  (byte_en_o),
    .misalign_o (misalign_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent model of one request
  task automatic model(input logic [63:0] src, input int sz, input bit rv, input int off,
                       output logic [63:0] ewd, output logic [7:0] ebe, output logic emis);
    int n;
    n    = 1 << sz;
    ewd  = '0;
    ebe  = '0;
    emis = ((off + n) > 8) || (rv && n == 1);
    if (!emis) begin
      for (int i = 0; i < n; i++) begin
        int lane;
        int rb;
        lane = off + i;
        rb   = rv ? i : (n - 1 - i);
        ewd[8*(7-lane) +: 8] = src[8*rb +: 8];
        ebe[lane] = 1'b1;
      end
    end
  endtask

  logic [63:0] last_wd;
  logic [7:0]  last_be;
  logic        last_mis;

  initial begin
    logic [63:0] pat;
    logic [63:0] ewd;
    logic [7:0]  ebe;
    logic        emis;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    in_vld_i = 1'b0;
    src_i = '0;
    size_i = '0;
    reverse_i = 1'b0;
    addr_lo_i = '0;

    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 out_vld_o", 64'(out_vld_o), 64'd0);
    check("R1 misalign_o", 64'(misalign_o), 64'd0);
    check("R1 wdata_o", wdata_o, 64'd0);
    check("R1 byte_en_o", 64'(byte_en_o), 64'd0);

    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 idle after reset", 64'(out_vld_o), 64'd0);

    for (int p = 0; p < 2; p++) begin
      pat = (p == 0) ? 64'h0123456789ABCDEF : 64'hF1E2D3C4B5A69788;
      for (int sz = 0; sz < 4; sz++) begin
        for (int rv = 0; rv < 2; rv++) begin
          for (int off = 0; off < 8; off++) begin
            in_vld_i  = 1'b1;
            src_i     = pat;
            size_i    = 2'(sz);
            reverse_i = rv[0];
            addr_lo_i = 3'(off);
            @(negedge clk);
            model(pat, sz, rv[0], off, ewd, ebe, emis);
            check("R2 out_vld_o", 64'(out_vld_o), 64'd1);
            if (sz == 3 && off == 0 && rv == 0)
              check("R6 full doubleword", wdata_o, ewd);
            else if (rv == 1)
              check("R5/R9/R10 wdata reversed", wdata_o, ewd);
            else
              check("R4/R9/R10 wdata normal", wdata_o, ewd);
            check("R3 byte_en_o", 64'(byte_en_o), 64'(ebe));
            if (rv == 1 && sz == 0)
              check("R8 reversed byte flag", 64'(misalign_o), 64'(emis));
            else
              check("R7 misalign_o", 64'(misalign_o), 64'(emis));
          end
        end
      end
    end

    // R11: idle cycles keep the last result while inputs wander
    last_wd  = wdata_o;
    last_be  = byte_en_o;
    last_mis = misalign_o;
    for (int j = 0; j < 3; j++) begin
      in_vld_i  = 1'b0;
      src_i     = 64'hDEADBEEFCAFEF00D ^ 64'(j);
      size_i    = 2'(j);
      reverse_i = j[0];
      addr_lo_i = 3'(j + 1);
      @(negedge clk);
      check("R2 no valid", 64'(out_vld_o), 64'd0);
      check("R11 wdata held", wdata_o, last_wd);
      check("R11 byte_en held", 64'(byte_en_o), 64'(last_be));
      check("R11 misalign held", 64'(misalign_o), 64'(last_mis));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule